// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio of M×N+A and emits one short compare pulse per full division period. It is the digital feedback path of a frequency synthesizer: a dual-modulus prescaler counter divides by either M or M+1. A main counter counts N prescaler cycles. A swallow counter keeps the prescaler at M+1 for the first A of those N cycles and at M for the rest. Small counters therefore produce a large ratio with single-cycle resolution.

A modulus-select input picks the prescaler pair: high selects 64/65 and low selects 128/129. The N and A values arrive from an external programming latch. The block samples them, together with the select bit, only at a period boundary, so the period in progress never changes length. An illegal setting, either N below 3 or A not smaller than N, is refused. In that case the block keeps its last legal setting and raises an error flag for the next period.

Top module: `swallowDivider`

## Requirements
- R1: Each output period lasts exactly N×M+A input clock cycles, where N, A and M are the values that apply to that period.
- R2: With `modSel` high the prescaler pair is 64/65 (M=64); with `modSel` low it is 128/129 (M=128).
- R3: With A=0 the prescaler divides by M for the whole period, giving a period of exactly N×M cycles.
- R4: The swallow count covers its full 7-bit range, so A=127 with a large N adds exactly 127 cycles.
- R5: A setting with N below 3 is refused. The previous legal setting stays in use and `cfgErr` is high for the period that the refused setting would have governed.
- R6: A setting with A greater than or equal to N is refused in the same way as in R5. The next legal setting clears `cfgErr` when it is loaded.
- R7: `divOut` is high for exactly one input clock cycle per period, and it is high in the first cycle of each new period.
- R8: The inputs `nSet`, `aSet` and `modSel` are sampled only at a period boundary. Any values applied and withdrawn in the middle of a period have no effect on period lengths or on `cfgErr`.
- R9: While `rstN` is low, `divOut` and `cfgErr` are low. The first period starts one clock after reset release with the inputs present at that time, so the first pulse appears N×M+A+1 rising edges after release.
- R10: The smallest legal main count, N=3, is accepted, and so is A=N−1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided (digital prescaler input) |
| rstN | input | 1 | Active-low synchronous reset |
| modSel | input | 1 | Prescaler pair select: 1 = 64/65, 0 = 128/129 |
| nSet | input | 11 | Main counter setting N (legal 3 to 2047) |
| aSet | input | 7 | Swallow counter setting A (legal 0 to 127, below N) |
| divOut | output | 1 | One-cycle compare pulse, one per divided period |
| cfgErr | output | 1 | Illegal setting seen at the last period boundary |

## Verification
On every cycle the assertions check the following:
- the output pulse never lasts longer than one cycle;
- the spacing between pulses stays within the smallest and largest ratios the counter widths allow;
- the error flag only moves on a load strobe;
- every prescaler reload length is either M or M+1 of a legal pair.

These properties cannot show that a given N, A and select produce exactly N×M+A cycles. Nor can they show that a refused setting leaves the previous ratio in force, or that values changed mid-period are ignored. The bench scenarios measure exact pulse spacing against a model to cover those points, as well as the first-pulse latency after reset.

// File: rtl/divPkg.sv
package divPkg;
  // Strobes from control to datapath, all valid in the same cycle
  typedef struct packed {
    logic load;       // boundary: sample settings, reload counters
    logic presEnd;    // last input cycle of a prescaler cycle
    logic periodEnd;  // last input cycle of a full division period
  } divStrobe_t;
endpackage

// File: rtl/swallowDatapath.sv
module swallowDatapath
  import divPkg::*;
#(
  parameter int NW      = 11,
  parameter int AW      = 7,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128,
  parameter int N_MIN   = 3,
  parameter int DEF_N   = 3,
  parameter int DEF_A   = 0,
  parameter bit DEF_SEL = 1'b1,
  parameter int PW      = $clog2(M_LARGE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  divStrobe_t    strobe,
  input  logic          modSel,
  input  logic [NW-1:0] nSet,
  input  logic [AW-1:0] aSet,
  output logic          lastPresc,
  output logic [PW-1:0] lenM1,
  output logic          cfgErr
);
  // Active (legal) configuration
  logic [NW-1:0] cfgN;
  logic [AW-1:0] cfgA;
  logic          cfgSel;
  // Running counters
  logic [NW-1:0] nRem;
  logic [AW-1:0] aRem;

  logic          inLegal;
  logic [NW-1:0] nNew;
  logic [AW-1:0] aNew;
  logic          selNew;
  logic [AW-1:0] aNext;
  logic          selNext;

  always_comb begin
    inLegal = (nSet >= NW'(N_MIN)) && (NW'(aSet) < nSet);
    nNew    = inLegal ? nSet   : cfgN;
    aNew    = inLegal ? aSet   : cfgA;
    selNew  = inLegal ? modSel : cfgSel;
  end

  // Swallow count and modulus that govern the next prescaler cycle
  always_comb begin
    if (strobe.load) begin
      aNext   = aNew;
      selNext = selNew;
    end else if (strobe.presEnd) begin
      aNext   = (aRem != '0) ? aRem - AW'(1) : '0;
      selNext = cfgSel;
    end else begin
      aNext   = aRem;
      selNext = cfgSel;
    end
  end

  always_comb begin
    lenM1 = (selNext ? PW'(M_SMALL - 1) : PW'(M_LARGE - 1)) + PW'(aNext != '0);
  end

  assign lastPresc = (nRem == NW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgN   <= NW'(DEF_N);
      cfgA   <= AW'(DEF_A);
      cfgSel <= DEF_SEL;
      cfgErr <= 1'b0;
      nRem   <= NW'(1);
      aRem   <= '0;
    end else if (strobe.load) begin
      cfgN   <= nNew;
      cfgA   <= aNew;
      cfgSel <= selNew;
      cfgErr <= !inLegal;
      nRem   <= nNew;
      aRem   <= aNew;
    end else if (strobe.presEnd) begin
      nRem   <= nRem - NW'(1);
      aRem   <= aNext;
    end
  end
endmodule

// File: rtl/swallowCtrl.sv
module swallowCtrl
  import divPkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lastPresc,
  input  logic [PW-1:0] lenM1,
  output divStrobe_t    strobe,
  output logic          divOut
);
  logic [PW-1:0] pCnt;     // prescaler countdown within one prescaler cycle
  logic          started;  // first boundary after reset has happened

  always_comb begin
    strobe.presEnd   = started && (pCnt == '0);
    strobe.periodEnd = strobe.presEnd && lastPresc;
    strobe.load      = !started || strobe.periodEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pCnt    <= '0;
      started <= 1'b0;
      divOut  <= 1'b0;
    end else begin
      started <= 1'b1;
      divOut  <= strobe.periodEnd;
      if (strobe.load || strobe.presEnd) pCnt <= lenM1;
      else                               pCnt <= pCnt - PW'(1);
    end
  end
endmodule

// File: rtl/swallowDivider.sv
module swallowDivider
  import divPkg::*;
#(
  parameter int NW      = 11,
  parameter int AW      = 7,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128,
  parameter int N_MIN   = 3,
  parameter int DEF_N   = 3,
  parameter int DEF_A   = 0,
  parameter bit DEF_SEL = 1'b1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modSel,
  input  logic [NW-1:0] nSet,
  input  logic [AW-1:0] aSet,
  output logic          divOut,
  output logic          cfgErr
);
  localparam int PW = $clog2(M_LARGE + 1);

  divStrobe_t    strobe;
  logic          lastPresc;
  logic [PW-1:0] lenM1;

  swallowCtrl #(.PW(PW)) uCtrl (
    .clk(clk), .rstN(rstN), .lastPresc(lastPresc), .lenM1(lenM1),
    .strobe(strobe), .divOut(divOut)
  );

  swallowDatapath #(
    .NW(NW), .AW(AW), .M_SMALL(M_SMALL), .M_LARGE(M_LARGE), .N_MIN(N_MIN),
    .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_SEL(DEF_SEL), .PW(PW)
  ) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modSel(modSel),
    .nSet(nSet), .aSet(aSet), .lastPresc(lastPresc), .lenM1(lenM1),
    .cfgErr(cfgErr)
  );
endmodule

// File: rtl/swallowDividerChk.sv
module swallowDividerChk
  import divPkg::*;
#(
  parameter int NW      = 11,
  parameter int AW      = 7,
  parameter int M_SMALL = 64,
  parameter int M_LARGE = 128,
  parameter int N_MIN   = 3,
  parameter int PW      = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          divOut,
  input logic          cfgErr,
  input divStrobe_t    strobe,
  input logic [PW-1:0] lenM1
);
  localparam int GW      = NW + PW + 2;
  localparam int GAP_MIN = N_MIN * M_SMALL;
  localparam int GAP_MAX = ((1 << NW) - 1) * M_LARGE + ((1 << AW) - 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gap  <= '0;
      seen <= 1'b0;
    end else begin
      gap  <= divOut ? GW'(1) : gap + GW'(1);
      if (divOut) seen <= 1'b1;
    end
  end

  // R7: compare pulse is a single cycle wide
  a_r7_one_wide: assert property (@(posedge clk) disable iff (!rstN)
    divOut |=> !divOut);

  // R1: pulse spacing never below the smallest legal ratio
  a_r1_gap_floor: assert property (@(posedge clk) disable iff (!rstN)
    (divOut && seen) |-> (gap >= GW'(GAP_MIN)));

  // R1: counter never runs past the largest ratio
  a_r1_gap_ceiling: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> (gap <= GW'(GAP_MAX)));

  // R8: error flag only changes on a boundary load
  a_r8_err_at_load: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgErr) |-> $past(strobe.load));

  // R2: every prescaler reload is M or M+1 of one of the two pairs
  a_r2_len_range: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load || strobe.presEnd) |->
      ((lenM1 == PW'(M_SMALL - 1)) || (lenM1 == PW'(M_SMALL)) ||
       (lenM1 == PW'(M_LARGE - 1)) || (lenM1 == PW'(M_LARGE))));
endmodule

bind swallowDivider swallowDividerChk #(
  .NW(NW), .AW(AW), .M_SMALL(M_SMALL), .M_LARGE(M_LARGE), .N_MIN(N_MIN), .PW(PW)
) uChk (
  .clk(clk), .rstN(rstN), .divOut(divOut), .cfgErr(cfgErr),
  .strobe(strobe), .lenM1(lenM1)
);

// File: tb/tb_swallowDivider.sv
module tb_swallowDivider;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modSel;
  logic [10:0] nSet;
  logic [6:0]  aSet;
  logic        divOut;
  logic        cfgErr;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit finished = 0;

  int    lenQ[$];
  bit    errQ[$];
  string tagQ[$];

  localparam int NI = 9;
  int    itN[NI]   = '{3, 5, 2, 4, 10, 0, 1000, 20, 3};
  int    itA[NI]   = '{2, 0, 0, 4, 9, 0, 127, 7, 0};
  bit    itS[NI]   = '{1, 0, 1, 1, 0, 1, 1, 1, 1};
  bit    itJ[NI]   = '{0, 0, 0, 0, 0, 0, 0, 1, 0};
  string itT[NI]   = '{"R10 R1 N=3 A=2", "R2 R3 select low A=0", "R5 N below minimum",
                       "R6 A equal to N", "R6 R1 legal clears error", "R5 N zero",
                       "R4 A=127 large N", "R8 mid-period change", "R2 select high"};

  swallowDivider dut (
    .clk(clk), .rstN(rstN), .modSel(modSel), .nSet(nSet), .aSet(aSet),
    .divOut(divOut), .cfgErr(cfgErr)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  function automatic int lenOf(int n, int a, bit s);
    return n * (s ? 64 : 128) + a;
  endfunction

  function automatic bit legal(int n, int a);
    return (n >= 3) && (a < n);
  endfunction

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic waitPulse();
    do @(negedge clk); while (!divOut);
  endtask

  // Monitor: measures spacing between pulses and compares with queue
  initial begin : monitor
    int    last;
    int    e;
    bit    ee;
    string t;
    bit    seen;
    bit    prevHigh;
    last = 0; seen = 0; prevHigh = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (divOut && prevHigh) check(0, "R7 pulse wider than one clock", 2, 1);
        if (divOut && !prevHigh) begin
          if (!seen) begin
            check(cyc == 193, "R9 first pulse latency", cyc, 193);
            check(cfgErr == 1'b0, "R9 error flag after first load", cfgErr, 0);
            seen = 1;
          end else if (lenQ.size() == 0) begin
            check(0, "R7 unexpected extra pulse", 1, 0);
          end else begin
            e  = lenQ.pop_front();
            ee = errQ.pop_front();
            t  = tagQ.pop_front();
            check((cyc - last) == e, {t, " period"}, cyc - last, e);
            check(cfgErr == ee, {t, " error flag"}, cfgErr, ee);
          end
          last = cyc;
        end
        prevHigh = divOut;
      end
    end
  end

  // Driver
  initial begin : driver
    int aN, aA;
    bit aS;
    modSel = 1'b1; nSet = 11'd3; aSet = 7'd0;
    repeat (3) @(negedge clk);
    check(divOut == 1'b0, "R9 divOut low in reset", divOut, 0);
    check(cfgErr == 1'b0, "R9 cfgErr low in reset", cfgErr, 0);
    rstN = 1'b1;
    aN = 3; aA = 0; aS = 1;
    for (int i = 0; i < NI; i++) begin
      waitPulse();
      lenQ.push_back(lenOf(aN, aA, aS));
      errQ.push_back(!legal(itN[i], itA[i]));
      tagQ.push_back(itT[i]);
      if (itJ[i]) begin
        // R8: transient illegal values withdrawn before the boundary
        nSet = 11'd7; aSet = 7'd7; modSel = 1'b0;
        repeat (50) @(negedge clk);
      end
      nSet = 11'(itN[i]); aSet = 7'(itA[i]); modSel = itS[i];
      if (legal(itN[i], itA[i])) begin
        aN = itN[i]; aA = itA[i]; aS = itS[i];
      end
    end
    for (int k = 0; k < 2; k++) begin
      waitPulse();
      lenQ.push_back(lenOf(aN, aA, aS));
      errQ.push_back(1'b0);
      tagQ.push_back("R7 steady period");
    end
    waitPulse();
    @(negedge clk);
    check(lenQ.size() == 0, "R7 all expected pulses seen", lenQ.size(), 0);
    finished = 1;
    summary();
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule